// File: doc/BRIEF.md
# Video Frame CRC Signature Capture

This block forms a CRC signature over the pixel words of a video stream so that the display output can be compared, frame by frame, against a known-good value. It runs in the pixel clock domain. It samples a pixel data bus that a data-enable line qualifies, and it uses the falling edge of vertical sync to mark frame boundaries.

Software arms a capture by setting the enable control. Capture starts at the next falling edge of vertical sync. In single-frame mode it stops at the falling edge after that and raises a valid flag. In free-run mode the signature keeps accumulating across frames until free-run is cleared, and capture then stops at the end of the current frame. Clearing enable returns the signature to its seed and clears valid, ready for the next check. A mode input selects a 24-bit or a 32-bit CRC.

Top module: `vid_crc_sig`

## Requirements
- R1: `stat_word` bit 0 reflects the enable control, bit 1 reflects the free-run control and bit 2 is the valid flag. Bits 31:3 are always zero.
- R2: One clock after enable is seen low, `sig_out` equals the seed and `sig_valid` is 0. The seed is 000001h when `mode32`=0 and 00000000h when `mode32`=1.
- R3: After enable rises, pixels that arrive before the first falling edge of `vsync` leave `sig_out` at the seed.
- R4: During capture, each clock with `pix_de`=1 shifts the 24-bit pixel word into the CRC, most significant bit first. The CRC has no reflection and no final XOR. The polynomial is 04C11DB7h in 32-bit mode and 864CFBh in 24-bit mode. Clocks with `pix_de`=0 leave the signature unchanged.
- R5: With free-run at 0, capture ends at the second falling edge of `vsync` after arming. `sig_valid` is 0 before that edge and 1 after it. A pixel in the clock where the edge is detected is not included.
- R6: With free-run at 1, the signature carries across frame boundaries without reseeding, and `sig_valid` stays 0.
- R7: If free-run is cleared during a free-running capture, capture stops at the next falling edge of `vsync` and `sig_valid` is set. The signature then covers every frame since the start.
- R8: Once `sig_valid` is 1, `sig_out` and `sig_valid` hold while enable stays 1, whatever pixels or `vsync` edges arrive.
- R9: In 24-bit mode the signature occupies `sig_out[23:0]` and bits 31:24 read as zero. In 32-bit mode all 32 bits are significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | DW (24) | Pixel word |
| pix_de | input | 1 | Pixel qualifier |
| vsync | input | 1 | Vertical sync; its falling edge marks a frame boundary |
| ctl_en | input | 1 | Signature enable |
| ctl_free | input | 1 | Free-run select |
| mode32 | input | 1 | 1 selects the 32-bit CRC, 0 selects the 24-bit CRC |
| sig_out | output | 32 | Signature value |
| sig_valid | output | 1 | Signature complete and stable |
| stat_word | output | 32 | Control and status word |

## Verification
A wrong capture state shows at the ports in one of two ways. If the start edge is missed or taken too early, the final signature disagrees with the bit-serial model, because extra pixels or missing pixels change every bit. If the stop logic is wrong, `sig_valid` rises a frame early or late, or the signature drifts after valid, and this is visible within one frame of the faulty edge. A bad seed or a failure to reseed shows one clock after enable is cleared.

// File: rtl/vid_crc_sig.sv
module vid_crc_sig #(
  parameter int DW = 24,
  parameter logic [31:0] POLY32 = 32'h04C11DB7,
  parameter logic [23:0] POLY24 = 24'h864CFB
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_de,
  input  logic          vsync,
  input  logic          ctl_en,
  input  logic          ctl_free,
  input  logic          mode32,
  output logic [31:0]   sig_out,
  output logic          sig_valid,
  output logic [31:0]   stat_word
);
  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_DONE} st_t;

  st_t         st;
  logic        vs_q;
  logic [31:0] sig;
  logic        vfall;
  logic [31:0] seed;

  assign vfall     = vs_q & ~vsync;
  assign seed      = mode32 ? 32'h0 : 32'h1;
  assign sig_out   = sig;
  assign sig_valid = (st == S_DONE);
  assign stat_word = {29'b0, sig_valid, ctl_free, ctl_en};

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [DW-1:0] d,
                                           input logic m32);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = (m32 ? r[31] : r[23]) ^ d[i];
      r  = r << 1;
      if (!m32) r[31:24] = 8'h0;
      if (fb) r = r ^ (m32 ? POLY32 : {8'h0, POLY24});
    end
    return r;
  endfunction

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sig <= 32'h1;
    end else if (!ctl_en) begin
      st  <= S_IDLE;
      sig <= seed;
    end else begin
      case (st)
        S_IDLE: st <= S_ARM;
        S_ARM:  if (vfall) st <= S_RUN;
        S_RUN: begin
          if (vfall) begin
            if (!ctl_free) st <= S_DONE;
          end else if (pix_de) begin
            sig <= crc_step(sig, pix_data, mode32);
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_seed_when_off: assert property (@(posedge pclk) disable iff (!rst_n)
    !ctl_en |=> (sig_out == ($past(mode32) ? 32'h0 : 32'h1)) && !sig_valid);

  a_r5_valid_on_edge: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(sig_valid) |-> $past(vfall) && !$past(ctl_free));

  a_r3_no_update_armed: assert property (@(posedge pclk) disable iff (!rst_n)
    (st == S_ARM && ctl_en) |=> $stable(sig_out));

  a_r8_hold_after_valid: assert property (@(posedge pclk) disable iff (!rst_n)
    (sig_valid && ctl_en) |=> sig_valid && $stable(sig_out));

  a_r6_free_no_valid: assert property (@(posedge pclk) disable iff (!rst_n)
    (st == S_RUN && ctl_free) |=> !sig_valid);
endmodule

// File: tb/sim_vid_crc_sig.sv
module sim_vid_crc_sig;
  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_de = 1'b0, vsync = 1'b0, ctl_en = 1'b0, ctl_free = 1'b0, mode32 = 1'b0;
  logic [31:0] sig_out, stat_word;
  logic        sig_valid;
  int          errs = 0, checks = 0;
  logic [31:0] ref_sig;

  always #4 pclk = ~pclk;

  vid_crc_sig u0 (.pclk(pclk), .rst_n(rst_n), .pix_data(pix_data), .pix_de(pix_de),
    .vsync(vsync), .ctl_en(ctl_en), .ctl_free(ctl_free), .mode32(mode32),
    .sig_out(sig_out), .sig_valid(sig_valid), .stat_word(stat_word));

  function automatic logic [31:0] model(input logic [31:0] c, input logic [23:0] d,
                                        input logic m32);
    logic [31:0] r;
    logic        top;
    r = c;
    for (int k = 23; k >= 0; k--) begin
      if (m32) begin
        top = r[31] ^ d[k];
        r = {r[30:0], 1'b0} ^ (top ? 32'h04C11DB7 : 32'h0);
      end else begin
        top = r[23] ^ d[k];
        r = {8'h0, r[22:0], 1'b0} ^ (top ? 32'h00864CFB : 32'h0);
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge pclk); endtask

  task automatic pixels(input int n, input int salt, input bit acc);
    for (int i = 0; i < n; i++) begin
      pix_data = 24'(i * 24'h1F3D5) ^ 24'(salt * 24'h9A7C3);
      pix_de   = (i % 5) != 3;
      if (pix_de && acc) ref_sig = model(ref_sig, pix_data, mode32);
      tick();
    end
    pix_de = 1'b0;
  endtask

  task automatic vpulse();
    vsync = 1'b1; tick(); tick();
    vsync = 1'b0; tick();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic t_reset();
    chk("R2 reset seed", sig_out, 32'h1);
    chk("R1 reset status", stat_word, 32'h0);
    chk("R9 upper bits zero", {24'h0, sig_out[31:24]}, 32'h0);
  endtask

  task automatic t_single(input logic m);
    logic [31:0] sd;
    sd = m ? 32'h0 : 32'h1;
    mode32 = m; ctl_en = 1'b0; ctl_free = 1'b0; tick(); tick();
    chk("R2 seed", sig_out, sd);
    ctl_en = 1'b1; ref_sig = sd;
    pixels(4, 7, 1'b0);
    chk("R3 ignored before start", sig_out, sd);
    vpulse();
    pixels(11, m ? 5 : 1, 1'b1);
    chk("R5 not valid mid frame", {31'h0, sig_valid}, 32'h0);
    vpulse();
    chk("R5 valid at end", {31'h0, sig_valid}, 32'h1);
    chk(m ? "R9 R4 signature 32" : "R4 signature 24", sig_out, ref_sig);
    pixels(6, 3, 1'b0);
    vpulse();
    chk("R8 held signature", sig_out, ref_sig);
    chk("R8 held valid", {31'h0, sig_valid}, 32'h1);
    ctl_en = 1'b0; tick();
    chk("R2 reseed", sig_out, sd);
    chk("R2 valid cleared", {31'h0, sig_valid}, 32'h0);
  endtask

  task automatic t_free();
    mode32 = 1'b1; ctl_free = 1'b1; ctl_en = 1'b1; ref_sig = 32'h0; tick();
    chk("R1 status en+free", stat_word, 32'h3);
    vpulse();
    pixels(6, 11, 1'b1);
    vpulse();
    chk("R6 no valid", {31'h0, sig_valid}, 32'h0);
    chk("R6 accum frame1", sig_out, ref_sig);
    pixels(7, 12, 1'b1);
    vpulse();
    chk("R6 accum frame2", sig_out, ref_sig);
    pixels(4, 13, 1'b1);
    ctl_free = 1'b0;
    pixels(3, 14, 1'b1);
    chk("R7 still running", {31'h0, sig_valid}, 32'h0);
    vpulse();
    chk("R7 valid after stop", {31'h0, sig_valid}, 32'h1);
    chk("R7 signature", sig_out, ref_sig);
    chk("R1 status valid", stat_word, 32'h5);
    ctl_en = 1'b0; tick();
    chk("R2 reseed after free", sig_out, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_single(1'b0);
    t_single(1'b1);
    t_free();
    report();
  end
endmodule